// File: doc/BRIEF.md
# Debug Halt and Single-Step Controller

This block owns the run/halt state of a processor core while it is being debugged. It judges every decoded HALT opcode against the current privilege level and the debug enables: a permitted HALT stops the core, and a forbidden one is turned into an illegal-opcode request. The core then stays stopped until a GO command strobe arrives from the debug command logic.

With stepping enabled, the controller stops the core each time an instruction retires. Each GO therefore releases exactly one instruction. While stepping, a mask output can hold off pending interrupts, and a trace exception is steered either to supervisor-mode entry or to emulator-mode entry, as a configuration bit selects. The command transport and the pipeline are outside this block: the pipeline obeys `run_en_o`, and the exception logic uses the mask and the entry selects.

Top module: `dbg_step_ctrl`

## Requirements
- R1: After synchronous reset, `run_en_o`=1, `halted_o`=0 and `illegal_op_o`=0.
- R2: While running, a HALT decode with `dbg_en_i`=0 raises `illegal_op_o` for exactly the next cycle and does not halt the core.
- R3: With `dbg_en_i`=1 and `user_halt_en_i`=0, a HALT is legal when `user_mode_i`=0 (supervisor) and illegal when `user_mode_i`=1 (user).
- R4: With `dbg_en_i`=1 and `user_halt_en_i`=1, a HALT is legal in both user and supervisor mode.
- R5: A legal HALT decoded while running sets `halted_o`=1 and `run_en_o`=0 from the next cycle. Both hold until a GO strobe, and the core runs again in the cycle after the GO.
- R6: With `step_en_i`=1, an instruction retiring while running halts the core from the next cycle.
- R7: In step mode, a GO from the halted state lets the core run until one instruction retires, after which it is halted again.
- R8: A GO strobe while the core is running has no effect on `run_en_o` or `halted_o`.
- R9: `irq_mask_o` is 1 exactly when `step_en_i`=1 and `step_irq_ignore_i`=1, and 0 in all other cases.
- R10: In the cycle of `trace_exc_i`, `trace_emu_o`=1 if `trace_to_emu_i`=1, otherwise `trace_sup_o`=1. With no trace exception, both are 0.
- R11: Clearing `step_en_i` while halted does not resume the core. The next GO returns it to free running, in which retiring instructions do not halt it.
- R12: A HALT decode while halted raises no illegal-opcode pulse and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_en_i | input | 1 | Global debug enable |
| user_halt_en_i | input | 1 | Allow HALT in user mode |
| step_en_i | input | 1 | Single-step mode enable |
| step_irq_ignore_i | input | 1 | Mask interrupts while stepping |
| trace_to_emu_i | input | 1 | Trace exception enters emulator mode |
| retire_i | input | 1 | Instruction retired pulse |
| halt_op_i | input | 1 | HALT opcode decoded |
| user_mode_i | input | 1 | 1 = user, 0 = supervisor |
| go_i | input | 1 | GO command strobe |
| irq_pending_i | input | 1 | Interrupt request pending |
| trace_exc_i | input | 1 | Trace exception taken |
| run_en_o | output | 1 | Core may execute |
| halted_o | output | 1 | Core is halted |
| illegal_op_o | output | 1 | One-cycle illegal-opcode request |
| irq_mask_o | output | 1 | Interrupt acceptance blocked |
| irq_take_o | output | 1 | Pending interrupt may be serviced |
| trace_emu_o | output | 1 | Trace enters emulator mode |
| trace_sup_o | output | 1 | Trace enters supervisor mode |

## Verification
Three events can fall in the same cycle: a HALT decode, a step-mode retire and a GO strobe. A legal or illegal HALT can coincide with a retire under stepping, and a GO can coincide with either. The bench makes these overlaps directly, and it also lets random stimulus produce them. A bench model orders the effects the same way every time: a pending halt cause stops the core, an illegal HALT still pulses when stepping stops the core, and a GO that arrives while running is dropped.

// File: rtl/dbg_halt_pkg.sv
// Package: shared state type for the debug halt controller.
// Assumes: two-state run/halt sequencing is sufficient; stepping is a
// run state armed to stop on the next retire.
package dbg_halt_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_t;
endpackage

// File: rtl/dbg_halt_legal.sv
// Module: dbg_halt_legal
// Decides whether a decoded HALT is permitted. Only decodes seen while
// the core runs count. Assumes halt_op_i is a one-cycle decode strobe.
module dbg_halt_legal (
    input  logic dbg_en_i,
    input  logic user_halt_en_i,
    input  logic user_mode_i,
    input  logic halt_op_i,
    input  logic running_i,
    output logic halt_req_o,
    output logic halt_bad_o
);
    logic priv_ok;

    // Privilege and enable check for the HALT opcode
    always_comb begin
        priv_ok    = dbg_en_i && (!user_mode_i || user_halt_en_i);
        halt_req_o = running_i && halt_op_i && priv_ok;
        halt_bad_o = running_i && halt_op_i && !priv_ok;
    end
endmodule

// File: rtl/dbg_run_fsm.sv
// Module: dbg_run_fsm
// Holds the run/halt state and the registered illegal-opcode pulse.
// Assumes halt requests come pre-qualified from the legality stage and
// that a GO strobe is one cycle wide.
module dbg_run_fsm
    import dbg_halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req_i,
    input  logic halt_bad_i,
    input  logic step_en_i,
    input  logic retire_i,
    input  logic go_i,
    output logic run_en_o,
    output logic halted_o,
    output logic illegal_op_o
);
    run_state_t state_q, state_d;
    logic       step_stop;

    // Next-state: a halt cause stops the core, a GO releases it
    always_comb begin
        step_stop = step_en_i && retire_i;
        state_d   = state_q;
        case (state_q)
            ST_RUN:  if (halt_req_i || step_stop) state_d = ST_HALT;
            ST_HALT: if (go_i)                    state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State and illegal-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_RUN;
            illegal_op_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            illegal_op_o <= halt_bad_i;
        end
    end

    // Output decode of the run/halt state
    always_comb begin
        halted_o = (state_q == ST_HALT);
        run_en_o = (state_q == ST_RUN);
    end

    // R5
    property p_halt_hold;
        @(posedge clk) disable iff (!rst_n) (halted_o && !go_i) |=> halted_o;
    endproperty
    halt_hold_chk: assert property (p_halt_hold);

    // R5
    property p_go_release;
        @(posedge clk) disable iff (!rst_n) (halted_o && go_i) |=> run_en_o;
    endproperty
    go_release_chk: assert property (p_go_release);

    // R6
    property p_step_stop;
        @(posedge clk) disable iff (!rst_n) (run_en_o && step_en_i && retire_i) |=> halted_o;
    endproperty
    step_stop_chk: assert property (p_step_stop);

    // R8
    property p_go_ignored;
        @(posedge clk) disable iff (!rst_n)
            (run_en_o && go_i && !halt_req_i && !(step_en_i && retire_i)) |=> run_en_o;
    endproperty
    go_ignored_chk: assert property (p_go_ignored);

    // R2
    property p_bad_pulse;
        @(posedge clk) disable iff (!rst_n) halt_bad_i |=> illegal_op_o;
    endproperty
    bad_pulse_chk: assert property (p_bad_pulse);
endmodule

// File: rtl/dbg_irq_trace_gate.sv
// Module: dbg_irq_trace_gate
// Combinational interrupt gating during stepping and trace-exception
// mode steering. Assumes trace_exc_i is valid only in its own cycle.
module dbg_irq_trace_gate (
    input  logic step_en_i,
    input  logic step_irq_ignore_i,
    input  logic irq_pending_i,
    input  logic trace_exc_i,
    input  logic trace_to_emu_i,
    output logic irq_mask_o,
    output logic irq_take_o,
    output logic trace_emu_o,
    output logic trace_sup_o
);
    // Interrupt mask and service grant
    always_comb begin
        irq_mask_o = step_en_i && step_irq_ignore_i;
        irq_take_o = irq_pending_i && !irq_mask_o;
    end

    // Trace exception entry mode select
    always_comb begin
        trace_emu_o = trace_exc_i && trace_to_emu_i;
        trace_sup_o = trace_exc_i && !trace_to_emu_i;
    end

    // R10
    trace_excl_chk: assert final ($onehot0({trace_emu_o, trace_sup_o}));
endmodule

// File: rtl/dbg_step_ctrl.sv
// Module: dbg_step_ctrl (top)
// Debug halt and single-step controller. It ties together HALT legality,
// run/halt sequencing, and interrupt and trace gating. Assumes all inputs
// are synchronous to clk.
module dbg_step_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_en_i,
    input  logic user_halt_en_i,
    input  logic step_en_i,
    input  logic step_irq_ignore_i,
    input  logic trace_to_emu_i,
    input  logic retire_i,
    input  logic halt_op_i,
    input  logic user_mode_i,
    input  logic go_i,
    input  logic irq_pending_i,
    input  logic trace_exc_i,
    output logic run_en_o,
    output logic halted_o,
    output logic illegal_op_o,
    output logic irq_mask_o,
    output logic irq_take_o,
    output logic trace_emu_o,
    output logic trace_sup_o
);
    logic halt_req, halt_bad;

    dbg_halt_legal u_legal (
        .dbg_en_i       (dbg_en_i),
        .user_halt_en_i (user_halt_en_i),
        .user_mode_i    (user_mode_i),
        .halt_op_i      (halt_op_i),
        .running_i      (run_en_o),
        .halt_req_o     (halt_req),
        .halt_bad_o     (halt_bad)
    );

    dbg_run_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_req_i   (halt_req),
        .halt_bad_i   (halt_bad),
        .step_en_i    (step_en_i),
        .retire_i     (retire_i),
        .go_i         (go_i),
        .run_en_o     (run_en_o),
        .halted_o     (halted_o),
        .illegal_op_o (illegal_op_o)
    );

    dbg_irq_trace_gate u_gate (
        .step_en_i         (step_en_i),
        .step_irq_ignore_i (step_irq_ignore_i),
        .irq_pending_i     (irq_pending_i),
        .trace_exc_i       (trace_exc_i),
        .trace_to_emu_i    (trace_to_emu_i),
        .irq_mask_o        (irq_mask_o),
        .irq_take_o        (irq_take_o),
        .trace_emu_o       (trace_emu_o),
        .trace_sup_o       (trace_sup_o)
    );

    // R12
    property p_no_bad_when_halted;
        @(posedge clk) disable iff (!rst_n) halted_o |=> !illegal_op_o;
    endproperty
    no_bad_when_halted_chk: assert property (p_no_bad_when_halted);

    // R3
    property p_user_halt_blocked;
        @(posedge clk) disable iff (!rst_n)
            (run_en_o && halt_op_i && user_mode_i && !user_halt_en_i) |=> illegal_op_o;
    endproperty
    user_halt_blocked_chk: assert property (p_user_halt_blocked);
endmodule

// File: tb/test_dbg_step_ctrl.sv
module test_dbg_step_ctrl;
    logic clk = 1'b0;
    logic rst_n;
    logic dbg_en, uhe, step_en, irq_ign, to_emu, retire, halt_op, user_mode, go, irq_pend, trace_exc;
    logic run_en, halted, illegal, irq_mask, irq_take, t_emu, t_sup;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic exp_halted, exp_ill;

    always #2 clk = ~clk;

    dbg_step_ctrl i_dbg_step_ctrl (
        .clk(clk), .rst_n(rst_n), .dbg_en_i(dbg_en), .user_halt_en_i(uhe),
        .step_en_i(step_en), .step_irq_ignore_i(irq_ign), .trace_to_emu_i(to_emu),
        .retire_i(retire), .halt_op_i(halt_op), .user_mode_i(user_mode), .go_i(go),
        .irq_pending_i(irq_pend), .trace_exc_i(trace_exc),
        .run_en_o(run_en), .halted_o(halted), .illegal_op_o(illegal),
        .irq_mask_o(irq_mask), .irq_take_o(irq_take), .trace_emu_o(t_emu), .trace_sup_o(t_sup)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic idle();
        retire = 0; halt_op = 0; go = 0; trace_exc = 0; irq_pend = 0;
    endtask

    // One cycle: inputs already driven at negedge; checks combinational
    // outputs, advances the model, then checks registered outputs.
    task automatic cyc(input string tag);
        logic legal, n_halt, n_ill;
        #1;
        check(irq_mask, step_en & irq_ign, "R9 irq_mask");
        check(irq_take, irq_pend & ~(step_en & irq_ign), "R9 irq_take");
        check(t_emu, trace_exc & to_emu, "R10 trace_emu");
        check(t_sup, trace_exc & ~to_emu, "R10 trace_sup");
        legal  = dbg_en & (~user_mode | uhe);
        n_ill  = ~exp_halted & halt_op & ~legal;
        n_halt = exp_halted ? ~go : ((halt_op & legal) | (retire & step_en));
        @(posedge clk);
        #1;
        exp_halted = n_halt;
        exp_ill    = n_ill;
        check(halted, exp_halted, {tag, " halted"});
        check(run_en, ~exp_halted, {tag, " run_en"});
        check(illegal, exp_ill, {tag, " illegal"});
        @(negedge clk);
        idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        dbg_en = 1; uhe = 0; step_en = 0; irq_ign = 0; to_emu = 0; user_mode = 0;
        idle();
        rst_n = 0;
        exp_halted = 0; exp_ill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        check(run_en, 1'b1, "R1 run_en");
        check(halted, 1'b0, "R1 halted");
        check(illegal, 1'b0, "R1 illegal");

        // R8 GO while running ignored
        go = 1; cyc("R8");
        // R2 HALT with debug disabled
        dbg_en = 0; halt_op = 1; cyc("R2"); cyc("R2 after");
        dbg_en = 1;
        // R3 user HALT blocked, supervisor HALT accepted
        user_mode = 1; uhe = 0; halt_op = 1; cyc("R3 user");
        user_mode = 0; halt_op = 1; cyc("R3 sup");
        // R12 HALT while halted ignored; R5 holds
        halt_op = 1; cyc("R12"); cyc("R5 hold");
        go = 1; cyc("R5 go");
        // R4 user HALT with user-halt enabled
        uhe = 1; user_mode = 1; halt_op = 1; cyc("R4");
        go = 1; cyc("R4 go");
        // R6/R7 stepping
        step_en = 1; irq_ign = 1; irq_pend = 1; cyc("R9 pend");
        retire = 1; cyc("R6");
        go = 1; cyc("R7 go"); cyc("R7 run");
        retire = 1; cyc("R7 retire");
        // same-cycle: illegal HALT and step retire
        dbg_en = 0; go = 1; cyc("R7 go2");
        halt_op = 1; retire = 1; cyc("R2 R6 same cycle");
        dbg_en = 1;
        // R11 clear stepping while halted
        step_en = 0; cyc("R11 stays"); cyc("R11 stays2");
        go = 1; cyc("R11 go");
        retire = 1; cyc("R11 free"); retire = 1; cyc("R11 free2");
        // R10 trace
        trace_exc = 1; to_emu = 1; cyc("R10 emu");
        trace_exc = 1; to_emu = 0; cyc("R10 sup");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            dbg_en    = ($urandom % 8) != 0;
            uhe       = $urandom % 2;
            user_mode = $urandom % 2;
            step_en   = ($urandom % 4) != 0;
            irq_ign   = $urandom % 2;
            to_emu    = $urandom % 2;
            retire    = ($urandom % 3) == 0;
            halt_op   = ($urandom % 6) == 0;
            go        = ($urandom % 4) == 0;
            irq_pend  = $urandom % 2;
            trace_exc = ($urandom % 5) == 0;
            cyc("R5 R6 R7 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule